// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimate Unit

This unit turns one single-precision floating-point operand into a coarse approximation of its reciprocal. The approximation carries eight significant fraction bits and is intended as the seed for a later refinement sequence. An operand is offered with a valid strobe. One clock later the unit presents the packed single-precision result and a six-bit exception flag vector.

Three control inputs shape the answer. A two-bit rounding-mode field is used only where an answer saturates. A flush-to-zero switch replaces denormal operands by zero and turns very small results into zero. A default-NaN switch makes every NaN operand produce the canonical quiet NaN.

Finite operands are normalised, including denormal ones. The top eight fraction bits address a computed 256-entry table. The result exponent is mirrored around 253, and results that fall below the normal range are formed as denormals.

Top module: `recpe_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `res_out` and `flags_out` become zero.
- R2: `out_valid` equals the `in_valid` of the previous clock edge. When `in_valid` was low, `res_out` and `flags_out` keep their previous values.
- R3: For a normal operand with biased exponent e in 1..252, the result has exponent 253-e. Its fraction is the low 8 bits of the estimate in the top 8 fraction bits, with zeros below. The estimate is r=((2^19 div (2k+1))+1)>>1, where k is 256 plus the operand's top 8 fraction bits. The rounding mode and flush-to-zero have no effect in this case.
- R4: A NaN operand (exponent 255, fraction nonzero) returns itself with fraction bit 22 set. It raises invalid only if bit 22 was clear (signalling). With `dnan`=1 every NaN returns 0x7FC00000, and a signalling one still raises invalid.
- R5: An infinite operand returns zero with the operand's sign and no flags. A zero operand returns infinity with the operand's sign and raises divide-by-zero.
- R6: With `ftz`=1, a denormal operand is treated as a zero of the same sign and also raises input-denormal.
- R7: With `ftz`=0, a nonzero operand whose magnitude bits are below 0x00200000 raises overflow and inexact. `rmode` is encoded 0 nearest, 1 toward +inf, 2 toward -inf, 3 toward zero. The result is signed infinity for nearest, for toward +inf with a positive operand, and for toward -inf with a negative operand. In all other cases it is the signed largest normal, magnitude 0x7F7FFFFF.
- R8: With `ftz`=1, a finite operand with biased exponent 253 or 254 returns a signed zero and raises underflow.
- R9: With `ftz`=0, biased exponent 253 gives a result exponent field of 0 whose fraction is the R3 fraction shifted right by one with a 1 inserted at the top. Biased exponent 254 gives exponent field 0 with the R3 fraction shifted right by two and 01 inserted at the top.
- R10: With `ftz`=0, a denormal operand with fraction bit 22 set uses fraction bits 21..14 as the index and result exponent 253. One with bit 22 clear and bit 21 set uses bits 20..13 and result exponent 254.
- R11: The result sign always equals the operand sign, except for the default NaN, which is positive.
- R12: `flags_out` bit positions are 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact and 5 input-denormal. Operands of R3, R9 and R10 raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| op_in | input | 32 | Single-precision operand |
| rmode | input | 2 | Rounding mode for saturated results |
| ftz | input | 1 | Flush-to-zero enable |
| dnan | input | 1 | Default-NaN enable |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_out | output | 32 | Single-precision estimate |
| flags_out | output | 6 | Exception flags |

## Verification
The hardest corners to reach are the two denormal result shapes and the two denormal operand shapes. They occur only for exponents 253 and 254, or for a leading fraction bit at position 22 or 21, and only with flush-to-zero off. The stimulus table picks operands that sit exactly on those exponent and bit positions. It then repeats several of them with flush-to-zero on, so the same operand is seen taking the underflow or input-denormal path instead. The saturation case is covered by running two tiny operands, one of each sign, through all four rounding modes.

// File: rtl/recpe_pkg.sv
`timescale 1ns/1ps
// recpe_pkg: shared widths, flag positions, rounding and class encodings,
// and the constant function that builds the estimate table.
// Assumes IEEE-754 single-precision packing (sign, exponent, fraction).
package recpe_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int IDX_W   = 9;
    localparam int TOP_W   = IDX_W - 1;
    localparam int FLAG_W  = 6;

    localparam int FL_INV = 0;
    localparam int FL_DZ  = 1;
    localparam int FL_OVF = 2;
    localparam int FL_UNF = 3;
    localparam int FL_INX = 4;
    localparam int FL_IDN = 5;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_UP      = 2'd1,
        RM_DOWN    = 2'd2,
        RM_ZERO    = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        CL_NAN,
        CL_INF,
        CL_ZERO,
        CL_TINY,
        CL_BIG_FTZ,
        CL_FINITE
    } op_class_e;

    // Estimate for a table index k in [2^(w-1), 2^w): ((2^(2w+1) / (2k+1)) + 1) / 2
    function automatic int recip_seed(int k, int w);
        int num;
        num = 1 << (2 * w + 1);
        return ((num / (2 * k + 1)) + 1) >> 1;
    endfunction
endpackage

// File: rtl/recpe_classify.sv
`timescale 1ns/1ps
// recpe_classify: sorts an operand into its handling class, in priority order
// NaN, infinity, zero (after flushing), tiny, large-with-flush, finite.
// Assumes the sign has no bearing on the class.
module recpe_classify
    import recpe_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW-1:0] exp_f,
    input  logic [FW-1:0] frac_f,
    input  logic          ftz,
    output op_class_e     cls,
    output logic          snan,
    output logic          flushed
);
    localparam logic [EW-1:0] EXP_ALL1 = {EW{1'b1}};
    localparam logic [EW-1:0] EXP_BIG  = EXP_ALL1 - EW'(2);

    logic          is_den;
    logic [FW-1:0] frac_eff;

    // Flush decision: a denormal operand is squashed when ftz is set
    always_comb begin
        is_den   = (exp_f == '0) && (frac_f != '0);
        flushed  = ftz && is_den;
        frac_eff = flushed ? '0 : frac_f;
    end

    // Class selection in fixed priority order
    always_comb begin
        snan = 1'b0;
        if (exp_f == EXP_ALL1 && frac_f != '0) begin
            cls  = CL_NAN;
            snan = ~frac_f[FW-1];
        end else if (exp_f == EXP_ALL1) begin
            cls = CL_INF;
        end else if (exp_f == '0 && frac_eff == '0) begin
            cls = CL_ZERO;
        end else if (exp_f == '0 && frac_eff[FW-1 -: 2] == 2'b00) begin
            cls = CL_TINY;
        end else if (ftz && exp_f >= EXP_BIG) begin
            cls = CL_BIG_FTZ;
        end else begin
            cls = CL_FINITE;
        end
    end
endmodule

// File: rtl/recpe_table.sv
`timescale 1ns/1ps
// recpe_table: estimate lookup over the upper half of a W-bit index range.
// Entries are computed at elaboration; the always-set top bit is dropped.
// Assumes the caller supplies the index without its leading one.
module recpe_table
    import recpe_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic [IW-2:0] frac_top,
    output logic [IW-2:0] est_lo
);
    localparam int HALF = 1 << (IW - 1);

    logic [IW-2:0] rom [HALF];

    for (genvar g = 0; g < HALF; g++) begin : g_ent
        // One constant entry per index
        assign rom[g] = (IW-1)'(recip_seed(HALF + g, IW));
    end

    // Lookup
    assign est_lo = rom[frac_top];
endmodule

// File: rtl/recpe_mant.sv
`timescale 1ns/1ps
// recpe_mant: normalises a finite operand, looks up the estimate and forms
// the result exponent and fraction, including denormal result shapes.
// Assumes the operand is finite, nonzero and not tiny.
module recpe_mant
    import recpe_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W,
    parameter int TW = TOP_W
) (
    input  logic [EW-1:0] exp_f,
    input  logic [TW+1:0] frac_hi,
    output logic [EW-1:0] res_exp,
    output logic [FW-1:0] res_frac
);
    localparam int                   XW      = EW + 2;
    localparam int                   EXP_OFF = (1 << EW) - 3;
    localparam logic signed [XW-1:0] OFF_S   = XW'(EXP_OFF);
    localparam logic signed [XW-1:0] NEG1    = '1;

    logic [TW-1:0]          top;
    logic [TW-1:0]          est_lo;
    logic signed [XW-1:0]   exp_in;
    logic signed [XW-1:0]   rexp;
    logic [FW-1:0]          frac_base;

    // Normalisation: pick index bits and effective exponent
    always_comb begin
        if (exp_f == '0) begin
            if (frac_hi[TW+1]) begin
                top    = frac_hi[TW:1];
                exp_in = '0;
            end else begin
                top    = frac_hi[TW-1:0];
                exp_in = NEG1;
            end
        end else begin
            top    = frac_hi[TW+1:2];
            exp_in = {2'b00, exp_f};
        end
    end

    recpe_table #(.IW(TW + 1)) u_table (
        .frac_top (top),
        .est_lo   (est_lo)
    );

    // Result packing, with the two below-normal shapes
    always_comb begin
        rexp      = OFF_S - exp_in;
        frac_base = {est_lo, {(FW - TW){1'b0}}};
        if (rexp == '0) begin
            res_exp  = '0;
            res_frac = {1'b1, frac_base[FW-1:1]};
        end else if (rexp == NEG1) begin
            res_exp  = '0;
            res_frac = {2'b01, frac_base[FW-1:2]};
        end else begin
            res_exp  = rexp[EW-1:0];
            res_frac = frac_base;
        end
    end
endmodule

// File: rtl/recpe_unit.sv
`timescale 1ns/1ps
// recpe_unit: top of the reciprocal estimate unit. Selects the special-case
// or computed result, gathers flags and registers both for one cycle.
// Assumes a synchronous active-low reset and one operand per valid cycle.
module recpe_unit
    import recpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       op_in,
    input  logic [1:0]        rmode,
    input  logic              ftz,
    input  logic              dnan,
    output logic              out_valid,
    output logic [31:0]       res_out,
    output logic [5:0]        flags_out
);
    localparam logic [EXP_W-1:0]  EXP_ALL1 = {EXP_W{1'b1}};
    localparam logic [WORD_W-1:0] DEF_NAN  = {1'b0, EXP_ALL1, 1'b1, {(FRAC_W-1){1'b0}}};

    logic              sign;
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    op_class_e         cls;
    logic              snan;
    logic              flushed;
    logic [EXP_W-1:0]  m_exp;
    logic [FRAC_W-1:0] m_frac;
    rmode_e            rm;
    logic              to_inf;
    logic [WORD_W-1:0] res_c;
    logic [FLAG_W-1:0] flg_c;

    assign sign   = op_in[WORD_W-1];
    assign exp_f  = op_in[WORD_W-2 -: EXP_W];
    assign frac_f = op_in[FRAC_W-1:0];
    assign rm     = rmode_e'(rmode);

    recpe_classify u_class (
        .exp_f   (exp_f),
        .frac_f  (frac_f),
        .ftz     (ftz),
        .cls     (cls),
        .snan    (snan),
        .flushed (flushed)
    );

    recpe_mant u_mant (
        .exp_f    (exp_f),
        .frac_hi  (frac_f[FRAC_W-1 -: TOP_W+2]),
        .res_exp  (m_exp),
        .res_frac (m_frac)
    );

    // Saturation direction for tiny operands
    always_comb begin
        case (rm)
            RM_NEAREST: to_inf = 1'b1;
            RM_UP:      to_inf = ~sign;
            RM_DOWN:    to_inf = sign;
            default:    to_inf = 1'b0;
        endcase
    end

    // Result and flag selection per class
    always_comb begin
        flg_c         = '0;
        flg_c[FL_IDN] = flushed;
        case (cls)
            CL_NAN: begin
                res_c         = dnan ? DEF_NAN
                                     : {sign, EXP_ALL1, 1'b1, frac_f[FRAC_W-2:0]};
                flg_c[FL_INV] = snan;
            end
            CL_INF: begin
                res_c = {sign, {(WORD_W-1){1'b0}}};
            end
            CL_ZERO: begin
                res_c        = {sign, EXP_ALL1, {FRAC_W{1'b0}}};
                flg_c[FL_DZ] = 1'b1;
            end
            CL_TINY: begin
                res_c         = to_inf ? {sign, EXP_ALL1, {FRAC_W{1'b0}}}
                                       : {sign, EXP_ALL1 - EXP_W'(1), {FRAC_W{1'b1}}};
                flg_c[FL_OVF] = 1'b1;
                flg_c[FL_INX] = 1'b1;
            end
            CL_BIG_FTZ: begin
                res_c         = {sign, {(WORD_W-1){1'b0}}};
                flg_c[FL_UNF] = 1'b1;
            end
            default: begin
                res_c = {sign, m_exp, m_frac};
            end
        endcase
    end

    // Output register, loaded only on a valid operand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_out   <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_out   <= res_c;
                flags_out <= flg_c;
            end
        end
    end

    // R2: strobe follows the operand strobe by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: outputs hold without a new operand
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_out) && $stable(flags_out)));
    // R11: sign follows the operand unless the result is a NaN
    a_r11_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(res_out[WORD_W-2 -: EXP_W] == EXP_ALL1 && res_out[FRAC_W-1:0] != '0))
        |-> res_out[WORD_W-1] == $past(op_in[WORD_W-1]));
    // R5: divide-by-zero always comes with an infinite result
    a_r5_dz_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_out[FL_DZ]) |-> res_out[WORD_W-2:0] == {EXP_ALL1, {FRAC_W{1'b0}}});
    // R7: overflow and inexact are raised together
    a_r7_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> flags_out[FL_OVF] == flags_out[FL_INX]);
    // R4: invalid only accompanies a NaN result
    a_r4_invalid_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_out[FL_INV]) |-> (res_out[WORD_W-2 -: EXP_W] == EXP_ALL1 && res_out[FRAC_W-1]));
    // R8: underflow always gives a zero magnitude
    a_r8_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_out[FL_UNF]) |-> res_out[WORD_W-2:0] == '0);
    // R6: input-denormal requires flush-to-zero on the operand cycle
    a_r6_idn_ftz: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_out[FL_IDN]) |-> $past(ftz));
endmodule

// File: tb/recpe_unit_bench.sv
`timescale 1ns/1ps
module recpe_unit_bench;
    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] op;
        logic [1:0]  rm;
        logic        fz;
        logic        dn;
        logic [31:0] exp_res;
        logic [5:0]  exp_flg;
    } vec_t;

    localparam int NV = 44;
    // Flags: bit0 inv, bit1 dz, bit2 ovf, bit3 unf, bit4 inx, bit5 idn
    localparam vec_t VEC [NV] = '{
        '{4'd3,  32'h3F800000, 2'd0, 1'b0, 1'b0, 32'h3F7F8000, 6'h00}, // R3 1.0
        '{4'd3,  32'h40000000, 2'd0, 1'b0, 1'b0, 32'h3EFF8000, 6'h00}, // R3 2.0
        '{4'd3,  32'h3FC00000, 2'd0, 1'b0, 1'b0, 32'h3F2A8000, 6'h00}, // R3 1.5
        '{4'd3,  32'h3FFF8000, 2'd0, 1'b0, 1'b0, 32'h3F000000, 6'h00}, // R3 index 511
        '{4'd3,  32'h3F808000, 2'd0, 1'b0, 1'b0, 32'h3F7E8000, 6'h00}, // R3 index 257
        '{4'd3,  32'h3F807FFF, 2'd0, 1'b0, 1'b0, 32'h3F7F8000, 6'h00}, // R3 low bits ignored
        '{4'd3,  32'h3F800000, 2'd3, 1'b1, 1'b0, 32'h3F7F8000, 6'h00}, // R3 rmode/ftz no effect
        '{4'd3,  32'h7E000000, 2'd0, 1'b1, 1'b0, 32'h00FF8000, 6'h00}, // R3 exp 252 with ftz
        '{4'd11, 32'hC0400000, 2'd0, 1'b0, 1'b0, 32'hBEAA8000, 6'h00}, // R11 -3.0
        '{4'd12, 32'h40000000, 2'd2, 1'b0, 1'b1, 32'h3EFF8000, 6'h00}, // R12 no flags
        '{4'd4,  32'h7FC01234, 2'd0, 1'b0, 1'b0, 32'h7FC01234, 6'h00}, // R4 qNaN
        '{4'd4,  32'h7F801234, 2'd0, 1'b0, 1'b0, 32'h7FC01234, 6'h01}, // R4 sNaN
        '{4'd4,  32'hFF800001, 2'd0, 1'b0, 1'b0, 32'hFFC00001, 6'h01}, // R4 neg sNaN
        '{4'd4,  32'h7F801234, 2'd0, 1'b0, 1'b1, 32'h7FC00000, 6'h01}, // R4 dnan sNaN
        '{4'd4,  32'hFFC00005, 2'd0, 1'b0, 1'b1, 32'h7FC00000, 6'h00}, // R4 dnan qNaN
        '{4'd5,  32'h7F800000, 2'd0, 1'b0, 1'b0, 32'h00000000, 6'h00}, // R5 +inf
        '{4'd5,  32'hFF800000, 2'd0, 1'b0, 1'b0, 32'h80000000, 6'h00}, // R5 -inf
        '{4'd5,  32'h00000000, 2'd0, 1'b0, 1'b0, 32'h7F800000, 6'h02}, // R5 +0
        '{4'd5,  32'h80000000, 2'd0, 1'b0, 1'b0, 32'hFF800000, 6'h02}, // R5 -0
        '{4'd6,  32'h00400000, 2'd0, 1'b1, 1'b0, 32'h7F800000, 6'h22}, // R6 flushed
        '{4'd6,  32'h80400000, 2'd0, 1'b1, 1'b0, 32'hFF800000, 6'h22}, // R6 flushed neg
        '{4'd6,  32'h001FFFFF, 2'd2, 1'b1, 1'b0, 32'h7F800000, 6'h22}, // R6 tiny flushed
        '{4'd7,  32'h001FFFFF, 2'd0, 1'b0, 1'b0, 32'h7F800000, 6'h14}, // R7 nearest +
        '{4'd7,  32'h001FFFFF, 2'd1, 1'b0, 1'b0, 32'h7F800000, 6'h14}, // R7 up +
        '{4'd7,  32'h001FFFFF, 2'd2, 1'b0, 1'b0, 32'h7F7FFFFF, 6'h14}, // R7 down +
        '{4'd7,  32'h001FFFFF, 2'd3, 1'b0, 1'b0, 32'h7F7FFFFF, 6'h14}, // R7 zero +
        '{4'd7,  32'h80000001, 2'd0, 1'b0, 1'b0, 32'hFF800000, 6'h14}, // R7 nearest -
        '{4'd7,  32'h80000001, 2'd1, 1'b0, 1'b0, 32'hFF7FFFFF, 6'h14}, // R7 up -
        '{4'd7,  32'h80000001, 2'd2, 1'b0, 1'b0, 32'hFF800000, 6'h14}, // R7 down -
        '{4'd7,  32'h80000001, 2'd3, 1'b0, 1'b0, 32'hFF7FFFFF, 6'h14}, // R7 zero -
        '{4'd8,  32'h7E800000, 2'd0, 1'b1, 1'b0, 32'h00000000, 6'h08}, // R8 exp 253
        '{4'd8,  32'hFF000000, 2'd0, 1'b1, 1'b0, 32'h80000000, 6'h08}, // R8 exp 254 neg
        '{4'd8,  32'h7F7FFFFF, 2'd0, 1'b1, 1'b0, 32'h00000000, 6'h08}, // R8 largest
        '{4'd9,  32'h7E800000, 2'd0, 1'b0, 1'b0, 32'h007FC000, 6'h00}, // R9 exp 253
        '{4'd9,  32'h7F000000, 2'd0, 1'b0, 1'b0, 32'h003FE000, 6'h00}, // R9 exp 254
        '{4'd9,  32'hFF000000, 2'd0, 1'b0, 1'b0, 32'h803FE000, 6'h00}, // R9 exp 254 neg
        '{4'd9,  32'h7F7FFFFF, 2'd0, 1'b0, 1'b0, 32'h00200000, 6'h00}, // R9 largest
        '{4'd10, 32'h00400000, 2'd0, 1'b0, 1'b0, 32'h7EFF8000, 6'h00}, // R10 bit22
        '{4'd10, 32'h00200000, 2'd0, 1'b0, 1'b0, 32'h7F7F8000, 6'h00}, // R10 bit21
        '{4'd10, 32'h00600000, 2'd0, 1'b0, 1'b0, 32'h7EAA8000, 6'h00}, // R10 index 384
        '{4'd11, 32'h80200000, 2'd0, 1'b0, 1'b0, 32'hFF7F8000, 6'h00}, // R11 neg denormal
        '{4'd10, 32'h00300000, 2'd0, 1'b0, 1'b0, 32'h7F2A8000, 6'h00}, // R10 bit21 index 384
        '{4'd12, 32'h00000001, 2'd0, 1'b1, 1'b1, 32'h7F800000, 6'h22}, // R12 idn position
        '{4'd12, 32'h3F800000, 2'd1, 1'b0, 1'b0, 32'h3F7F8000, 6'h00}  // R12 last
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_in;
    logic [1:0]  rmode;
    logic        ftz;
    logic        dnan;
    logic        out_valid;
    logic [31:0] res_out;
    logic [5:0]  flags_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    recpe_unit u_recpe_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_in     (op_in),
        .rmode     (rmode),
        .ftz       (ftz),
        .dnan      (dnan),
        .out_valid (out_valid),
        .res_out   (res_out),
        .flags_out (flags_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] last_res;
        logic [5:0]  last_flg;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        op_in    = 32'h3F800000;
        rmode    = 2'd0;
        ftz      = 1'b0;
        dnan     = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state, even with a valid operand offered
        check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R1", "res_out", res_out, 32'd0);
        check("R1", "flags_out", {26'd0, flags_out}, 32'd0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag      = $sformatf("R%0d", VEC[i].req);
            in_valid = 1'b1;
            op_in    = VEC[i].op;
            rmode    = VEC[i].rm;
            ftz      = VEC[i].fz;
            dnan     = VEC[i].dn;
            @(negedge clk);
            check("R2", "out_valid", {31'd0, out_valid}, 32'd1);
            check(tag, $sformatf("result op=%h", VEC[i].op), res_out, VEC[i].exp_res);
            check(tag, $sformatf("flags op=%h", VEC[i].op), {26'd0, flags_out},
                  {26'd0, VEC[i].exp_flg});
        end

        // R2 hold: new operand without strobe must not disturb outputs
        last_res = res_out;
        last_flg = flags_out;
        in_valid = 1'b0;
        op_in    = 32'h00000000;
        ftz      = 1'b1;
        @(negedge clk);
        check("R2", "idle out_valid", {31'd0, out_valid}, 32'd0);
        check("R2", "idle res_out", res_out, last_res);
        check("R2", "idle flags", {26'd0, flags_out}, {26'd0, last_flg});
        @(negedge clk);
        check("R2", "idle res_out 2", res_out, last_res);

        // R2 back-to-back after idle
        in_valid = 1'b1;
        op_in    = 32'h7F801234;
        ftz      = 1'b0;
        @(negedge clk);
        check("R2", "resume res", res_out, 32'h7FC01234);
        check("R2", "resume flags", {26'd0, flags_out}, 32'h01);

        // R1 reset in mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid reset valid", {31'd0, out_valid}, 32'd0);
        check("R1", "mid reset res", res_out, 32'd0);
        check("R1", "mid reset flags", {26'd0, flags_out}, 32'd0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule